// File: doc/BRIEF.md
# Register-Form Data-Processing Execute Stage

This block is the execute step for the register-operand data-processing instructions of a 32-bit load-store core. Each cycle it may accept one instruction word with `in_valid`. With it come two values already read from the register file, the incoming carry flag and the incoming overflow flag. The block decodes the operation and passes the second value through a shifter whose amount and kind come from the instruction. It then forms the result and the N, Z, C and V flags. All outputs are registered, so they appear one clock after the instruction is presented.

Downstream logic uses `out_wr_en` and `out_wr_reg` to write the register file, and `out_flags_we` to update the status flags. Compare and test operations only produce flags. An instruction word outside this class raises `out_unhandled` and changes nothing. Condition evaluation, register-specified shift amounts and immediate-operand forms are handled elsewhere.

Within the 32-bit word, the bit positions are fixed:
- Class bits are [27:25] and must be 000.
- Bit [4] must be 0.
- Bits [24:21] are the operation and bit [20] is the flag-update bit S.
- Bits [15:12] are the destination.
- Bits [11:7] are the shift amount.
- Bits [6:5] are the shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right.

Top module: `dpx_exec_unit`

## Requirements
- R1: The instruction is not handled when bits [27:25] are not 000, when bit [4] is 1, or when bits [24:20] match 10xx0. In that case `out_unhandled` is 1 and both `out_wr_en` and `out_flags_we` are 0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. `out_valid` is `in_valid` delayed one cycle. When `out_valid` is 0, no write and no flag update is signalled.
- R3: The logical operation codes in bits [24:21] give these results, where S2 is the shifted second operand:
  - 0000: first AND S2
  - 0001: first XOR S2
  - 1100: first OR S2
  - 1101: S2 (move)
  - 1110: first AND NOT S2
  - 1111: NOT S2
- R4: The arithmetic operation codes give these results, with Cin the incoming carry:
  - 0010: first − S2
  - 0011: S2 − first
  - 0100: first + S2
  - 0101: first + S2 + Cin
  - 0110: first − S2 − (1−Cin)
  - 0111: S2 − first − (1−Cin)
- R5: Bits [24:20] equal to 10001, 10011, 10101 and 10111 compute first AND S2, first XOR S2, first − S2 and first + S2 respectively. They set `out_flags_we` and never set `out_wr_en`.
- R6: For a nonzero amount k, each shift kind acts as follows:
  - Left shift gives S2 = B<<k, with carry-out B[32−k].
  - Logical right gives B>>k, with carry-out B[k−1].
  - Arithmetic right gives a sign-filling shift, with carry-out B[k−1].
  - Rotate right rotates by k, with carry-out being the new bit 31.
- R7: A zero amount has a special meaning for each shift kind:
  - Left shift passes B unchanged, with carry-out equal to the incoming carry.
  - Logical right and arithmetic right act as a shift of 32: the result is all zeros or all copies of B[31], with carry-out B[31].
  - Rotate right becomes a one-bit rotate through carry, {Cin, B[31:1]}, with carry-out B[0].
- R8: N is result bit 31 and Z is 1 exactly when the 32-bit result is zero. For logical operations C is the shifter carry-out and V is the incoming overflow. For arithmetic operations C is the unsigned carry (1 means no borrow for subtraction) and V is two's-complement overflow.
- R9: `out_flags_we` is 1 for a handled valid instruction exactly when bit [20] is 1. `out_wr_en` is 1 for handled valid non-compare instructions, whatever the value of bit [20]. `out_wr_reg` equals bits [15:12].
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_instr | input | 32 | Instruction word |
| in_op1 | input | DATA_W | First operand value |
| in_op2 | input | DATA_W | Second operand value, before shifting |
| in_carry | input | 1 | Incoming C flag |
| in_ovf | input | 1 | Incoming V flag |
| out_valid | output | 1 | Result of last cycle's instruction is present |
| out_result | output | DATA_W | Computed value (also for compare/test) |
| out_wr_en | output | 1 | Write `out_result` to the destination register |
| out_wr_reg | output | 4 | Destination register number |
| out_flags_we | output | 1 | Update the status flags with `out_n..out_v` |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |
| out_v | output | 1 | Overflow flag |
| out_unhandled | output | 1 | Instruction word outside this class |

## Verification
The bench builds the block with its default `DATA_W` of 32. This is the only width for which the instruction fields mean anything. The sweep covers all 32 values of bits [24:20], all four shift kinds and all 32 shift amounts. Each combination is tried with five operand pairs chosen to hit signed and unsigned overflow, zero results and sign fill, and with both carry values. This brings every zero-amount special case, every carry-out bit position and every compare/test encoding within reach. Further words with foreign class bits or bit [4] set exercise the not-handled path.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

    typedef enum logic [3:0] {
        ALU_AND, ALU_EOR, ALU_SUB, ALU_RSB,
        ALU_ADD, ALU_ADC, ALU_SBC, ALU_RSC,
        ALU_ORR, ALU_MOV, ALU_BIC, ALU_MVN
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;

    typedef struct packed {
        alu_op_e    op;
        logic       arith;
        logic       writes;
        logic       handled;
        logic       set_flags;
        shift_e     sh;
        logic [4:0] amt;
        logic [3:0] rd;
    } dec_t;

endpackage

// File: rtl/dpx_decode.sv
module dpx_decode
    import dpx_pkg::*;
(
    input  logic [27:4] fields,
    output dec_t        dec
);
    logic [3:0] opc;
    logic       sbit;
    logic       foreign;

    assign opc     = fields[24:21];
    assign sbit    = fields[20];
    // 10xx0 belongs to another class; bit 4 set means register-specified shift
    assign foreign = (fields[24:23] == 2'b10) && !sbit;

    always_comb begin
        dec.handled   = (fields[27:25] == 3'b000) && !fields[4] && !foreign;
        dec.set_flags = sbit;
        dec.sh        = shift_e'(fields[6:5]);
        dec.amt       = fields[11:7];
        dec.rd        = fields[15:12];
        dec.writes    = 1'b1;
        dec.arith     = 1'b0;
        dec.op        = ALU_AND;
        case (opc)
            4'b0000: dec.op = ALU_AND;
            4'b0001: dec.op = ALU_EOR;
            4'b0010: begin dec.op = ALU_SUB; dec.arith = 1'b1; end
            4'b0011: begin dec.op = ALU_RSB; dec.arith = 1'b1; end
            4'b0100: begin dec.op = ALU_ADD; dec.arith = 1'b1; end
            4'b0101: begin dec.op = ALU_ADC; dec.arith = 1'b1; end
            4'b0110: begin dec.op = ALU_SBC; dec.arith = 1'b1; end
            4'b0111: begin dec.op = ALU_RSC; dec.arith = 1'b1; end
            4'b1000: begin dec.op = ALU_AND; dec.writes = 1'b0; end
            4'b1001: begin dec.op = ALU_EOR; dec.writes = 1'b0; end
            4'b1010: begin dec.op = ALU_SUB; dec.arith = 1'b1; dec.writes = 1'b0; end
            4'b1011: begin dec.op = ALU_ADD; dec.arith = 1'b1; dec.writes = 1'b0; end
            4'b1100: dec.op = ALU_ORR;
            4'b1101: dec.op = ALU_MOV;
            4'b1110: dec.op = ALU_BIC;
            default: dec.op = ALU_MVN;
        endcase
    end
endmodule

// File: rtl/dpx_shifter.sv
module dpx_shifter
    import dpx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] b,
    input  shift_e            sh,
    input  logic [AMT_W-1:0]  amt,
    input  logic              cin,
    output logic [DATA_W-1:0] s,
    output logic              cout
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]        up;
    logic [EXT_W-1:0]        dn;
    logic signed [EXT_W-1:0] dn_s;
    logic [DATA_W-1:0]       rot;
    logic                    zero_amt;

    assign zero_amt = (amt == '0);
    assign up   = {1'b0, b} << amt;
    assign dn   = {b, 1'b0} >> amt;
    assign dn_s = $signed({b, 1'b0}) >>> amt;
    assign rot  = (b >> amt) | (b << (DATA_W - int'(amt)));

    always_comb begin
        s    = b;
        cout = cin;
        case (sh)
            SH_LSL: if (!zero_amt) begin
                s    = up[DATA_W-1:0];
                cout = up[DATA_W];
            end
            SH_LSR: if (zero_amt) begin
                s    = '0;
                cout = b[DATA_W-1];
            end else begin
                s    = dn[DATA_W:1];
                cout = dn[0];
            end
            SH_ASR: if (zero_amt) begin
                s    = {DATA_W{b[DATA_W-1]}};
                cout = b[DATA_W-1];
            end else begin
                s    = dn_s[DATA_W:1];
                cout = dn_s[0];
            end
            default: if (zero_amt) begin
                s    = {cin, b[DATA_W-1:1]};
                cout = b[0];
            end else begin
                s    = rot;
                cout = rot[DATA_W-1];
            end
        endcase
    end
endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
    import dpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] s,
    input  logic              cin,
    input  logic              vin,
    input  logic              sh_c,
    output logic [DATA_W-1:0] res,
    output logic              n,
    output logic              z,
    output logic              c,
    output logic              v
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x, y;
    logic              ci;
    logic              is_arith;
    logic [DATA_W:0]   sum;

    always_comb begin
        x = a; y = s; ci = 1'b0; is_arith = 1'b1;
        case (op)
            ALU_SUB: begin x = a; y = ~s; ci = 1'b1; end
            ALU_RSB: begin x = s; y = ~a; ci = 1'b1; end
            ALU_ADD: begin x = a; y = s;  ci = 1'b0; end
            ALU_ADC: begin x = a; y = s;  ci = cin;  end
            ALU_SBC: begin x = a; y = ~s; ci = cin;  end
            ALU_RSC: begin x = s; y = ~a; ci = cin;  end
            default: is_arith = 1'b0;
        endcase
    end

    assign sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};

    always_comb begin
        case (op)
            ALU_AND: res = a & s;
            ALU_EOR: res = a ^ s;
            ALU_ORR: res = a | s;
            ALU_MOV: res = s;
            ALU_BIC: res = a & ~s;
            ALU_MVN: res = ~s;
            default: res = sum[DATA_W-1:0];
        endcase
    end

    assign n = res[MSB];
    assign z = (res == '0);
    assign c = is_arith ? sum[DATA_W] : sh_c;
    assign v = is_arith ? ((x[MSB] == y[MSB]) && (sum[MSB] != x[MSB])) : vin;
endmodule

// File: rtl/dpx_exec_unit.sv
module dpx_exec_unit
    import dpx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    input  logic [DATA_W-1:0] in_op1,
    input  logic [DATA_W-1:0] in_op2,
    input  logic              in_carry,
    input  logic              in_ovf,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_wr_en,
    output logic [3:0]        out_wr_reg,
    output logic              out_flags_we,
    output logic              out_n,
    output logic              out_z,
    output logic              out_c,
    output logic              out_v,
    output logic              out_unhandled
);
    localparam int AMT_W = 5;

    dec_t              dec;
    logic [DATA_W-1:0] s2, res;
    logic              sh_c, fn, fz, fc, fv;
    logic              unused_fields;

    assign unused_fields = ^{in_instr[31:28], in_instr[19:16], in_instr[3:0]};

    dpx_decode u_dec (.fields(in_instr[27:4]), .dec(dec));

    dpx_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_sh (
        .b(in_op2), .sh(dec.sh), .amt(dec.amt), .cin(in_carry),
        .s(s2), .cout(sh_c)
    );

    dpx_alu #(.DATA_W(DATA_W)) u_alu (
        .op(dec.op), .a(in_op1), .s(s2), .cin(in_carry), .vin(in_ovf),
        .sh_c(sh_c), .res(res), .n(fn), .z(fz), .c(fc), .v(fv)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_wr_en     <= 1'b0;
            out_wr_reg    <= '0;
            out_flags_we  <= 1'b0;
            out_n         <= 1'b0;
            out_z         <= 1'b0;
            out_c         <= 1'b0;
            out_v         <= 1'b0;
            out_unhandled <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            out_result    <= res;
            out_wr_en     <= in_valid && dec.handled && dec.writes;
            out_wr_reg    <= dec.rd;
            out_flags_we  <= in_valid && dec.handled && dec.set_flags;
            out_n         <= fn;
            out_z         <= fz;
            out_c         <= fc;
            out_v         <= fv;
            out_unhandled <= in_valid && !dec.handled;
        end
    end

    assert_unhandled_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_unhandled |-> (!out_wr_en && !out_flags_we));

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wr_en && !out_flags_we && !out_unhandled));

    assert_compare_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_instr[27:25] == 3'b000 && !in_instr[4]
              && in_instr[24:23] == 2'b10 && in_instr[20])
        |-> (!out_wr_en && out_flags_we));

    assert_neg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags_we |-> (out_n == out_result[DATA_W-1] && out_z == (out_result == '0)));

    assert_ovf_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_flags_we && $past(!dec.arith)) |-> (out_v == $past(in_ovf)));

    assert_flag_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags_we |-> $past(in_instr[20]));
endmodule

// File: tb/test_dpx_exec_unit.sv
module test_dpx_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_op1 = '0;
    logic [31:0] in_op2 = '0;
    logic        in_carry = 1'b0;
    logic        in_ovf = 1'b0;
    logic        out_valid, out_wr_en, out_flags_we, out_unhandled;
    logic        out_n, out_z, out_c, out_v;
    logic [31:0] out_result;
    logic [3:0]  out_wr_reg;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dpx_exec_unit #(.DATA_W(32)) i_dpx_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_op1(in_op1), .in_op2(in_op2), .in_carry(in_carry), .in_ovf(in_ovf),
        .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
        .out_wr_reg(out_wr_reg), .out_flags_we(out_flags_we), .out_n(out_n),
        .out_z(out_z), .out_c(out_c), .out_v(out_v), .out_unhandled(out_unhandled)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (instr %h)", tag, what, act, exp, in_instr);
        end
    endtask

    // Independent model built from the requirements
    task automatic model(input logic [31:0] ins, a, b, input logic cin, vin,
                         output logic [31:0] r, output logic n, z, c, v,
                         output logic wr, fwe, unh, arith);
        logic [4:0]  opf;
        logic [1:0]  ty;
        logic [4:0]  k5;
        int          k;
        logic [31:0] s;
        logic        sc;
        logic [32:0] t;
        logic signed [32:0] ts;
        longint ua, us, ux, tot, sx, sy, stot, bor;
        bit isub;
        opf = ins[24:20]; ty = ins[6:5]; k5 = ins[11:7];
        unh = (ins[27:25] != 3'b000) || ins[4] || (opf[4:3] == 2'b10 && !opf[0]);
        k = (k5 == 0) ? 32 : int'(k5);
        s = b; sc = cin;
        case (ty)
            2'b00: if (k5 != 0) begin t = {1'b0, b} << k5; s = t[31:0]; sc = t[32]; end
            2'b01: begin t = {b, 1'b0} >> k; s = t[32:1]; sc = t[0]; end
            2'b10: begin ts = $signed({b, 1'b0}); ts = ts >>> k; s = ts[32:1]; sc = ts[0]; end
            default: if (k5 == 0) begin s = {cin, b[31:1]}; sc = b[0]; end
                     else begin s = (b >> k5) | (b << (32 - k)); sc = s[31]; end
        endcase
        arith = 1'b0; wr = 1'b1; v = vin; c = sc; r = '0;
        ua = longint'(a); us = longint'(s);
        sx = longint'($signed(a)); sy = longint'($signed(s));
        ux = 0; tot = 0; stot = 0; isub = 0; bor = 0;
        case (opf[4:1])
            4'b0000, 4'b1000: r = a & s;
            4'b0001, 4'b1001: r = a ^ s;
            4'b1100: r = a | s;
            4'b1101: r = s;
            4'b1110: r = a & ~s;
            4'b1111: r = ~s;
            default: begin
                arith = 1'b1;
                case (opf[4:1])
                    4'b0010, 4'b1010: begin isub = 1; ux = ua; tot = us; stot = sy; bor = 0; end
                    4'b0011: begin isub = 1; ux = us; tot = ua; stot = sx; bor = 0; end
                    4'b0100, 4'b1011: begin isub = 0; ux = ua; tot = us; stot = sy; bor = 0; end
                    4'b0101: begin isub = 0; ux = ua; tot = us; stot = sy; bor = longint'(cin); end
                    4'b0110: begin isub = 1; ux = ua; tot = us; stot = sy; bor = longint'(!cin); end
                    default: begin isub = 1; ux = us; tot = ua; stot = sx; bor = longint'(!cin); end
                endcase
                if (isub) begin
                    sx = (opf[4:1] == 4'b0011 || opf[4:1] == 4'b0111) ? sy : sx;
                    c = (ux - tot - bor) >= 0;
                    r = 32'(ux - tot - bor);
                    stot = sx - stot - bor;
                end else begin
                    c = ((ux + tot + bor) >> 32) != 0;
                    r = 32'(ux + tot + bor);
                    stot = sx + stot + bor;
                end
                v = (stot > 64'sd2147483647) || (stot < -64'sd2147483648);
            end
        endcase
        if (opf[4:3] == 2'b10) wr = 1'b0;
        n = r[31]; z = (r == 0);
        fwe = !unh && opf[0];
        wr = wr && !unh;
    endtask

    task automatic run(input logic [31:0] ins, a, b, input logic cin, vin);
        logic [31:0] er;
        logic en, ez, ec, ev, ewr, efwe, eunh, earith;
        string rtag;
        model(ins, a, b, cin, vin, er, en, ez, ec, ev, ewr, efwe, eunh, earith);
        in_valid = 1'b1; in_instr = ins; in_op1 = a; in_op2 = b;
        in_carry = cin; in_ovf = vin;
        @(negedge clk);
        chk("R2", "out_valid", {31'b0, out_valid}, 32'd1);
        chk("R1", "unhandled", {31'b0, out_unhandled}, {31'b0, eunh});
        if (!eunh) begin
            if (earith) rtag = "R4";
            else if (ins[24:21] == 4'b1101 || ins[24:21] == 4'b1111)
                rtag = (ins[11:7] == 0) ? "R7" : "R6";
            else rtag = "R3";
            if (ewr) chk(rtag, "result", out_result, er);
            else chk("R5", "result", out_result, er);
            chk((ins[24:23] == 2'b10) ? "R5" : "R9", "wr_en", {31'b0, out_wr_en}, {31'b0, ewr});
            chk("R9", "flags_we", {31'b0, out_flags_we}, {31'b0, efwe});
            chk("R9", "wr_reg", {28'b0, out_wr_reg}, {28'b0, ins[15:12]});
            chk("R8", "nzcv", {28'b0, out_n, out_z, out_c, out_v}, {28'b0, en, ez, ec, ev});
        end else begin
            chk("R1", "no write", {30'b0, out_wr_en, out_flags_we}, 32'd0);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa [5];
        logic [31:0] pb [5];
        pa[0] = 32'h7FFF_FFFF; pb[0] = 32'h0000_0001;
        pa[1] = 32'h8000_0000; pb[1] = 32'h8000_0000;
        pa[2] = 32'h1234_5678; pb[2] = 32'hF0F0_000F;
        pa[3] = 32'h0000_0000; pb[3] = 32'h0000_0000;
        pa[4] = 32'hFFFF_FFFF; pb[4] = 32'h0000_0001;
        in_instr = 32'hFFFF_FFFF; in_op1 = '1; in_op2 = '1; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset holds every output at zero
        chk("R10", "reset outputs",
            {out_result[0], out_valid, out_wr_en, out_flags_we, out_unhandled,
             out_n, out_z, out_c, out_v, out_wr_reg, 19'b0}, 32'd0);
        chk("R10", "reset result", out_result, 32'd0);
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R2: idle cycle signals nothing
        chk("R2", "idle", {28'b0, out_valid, out_wr_en, out_flags_we, out_unhandled}, 32'd0);

        for (int op = 0; op < 32; op++)
            for (int ty = 0; ty < 4; ty++)
                for (int am = 0; am < 32; am++)
                    for (int p = 0; p < 5; p++)
                        for (int ci = 0; ci < 2; ci++) begin
                            logic [31:0] ins;
                            ins = {4'hE, 3'b000, 5'(op), 4'h3, 4'(op) ^ 4'(am),
                                   5'(am), 2'(ty), 1'b0, 4'h7};
                            run(ins, pa[p], pb[p], ci[0], am[0] ^ p[0]);
                        end

        // R1: foreign class bits and bit 4 set
        for (int cl = 1; cl < 8; cl++)
            run({4'hE, 3'(cl), 5'b01001, 4'h1, 4'h2, 5'd3, 2'b00, 1'b0, 4'h4},
                32'h5, 32'h9, 1'b0, 1'b0);
        run({4'hE, 3'b000, 5'b00101, 4'h1, 4'h2, 5'd0, 2'b00, 1'b1, 4'h4},
            32'h5, 32'h9, 1'b1, 1'b0);

        in_valid = 1'b0;
        @(negedge clk);
        chk("R2", "valid drop", {30'b0, out_valid, out_wr_en}, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule